// File: doc/BRIEF.md
# USB Endpoint Control and Status Register Set

This block holds the software-visible control and status state for the endpoints of a USB device controller: four IN endpoints and four OUT endpoints. Software reaches it over a plain 32-bit register bus with a write strobe, an address and combinational read data. Each endpoint keeps its halt (stall) setting, its transfer kind and an active flag. It accepts one-shot flush and transmit-start commands. It tracks a NAK state, which software moves only through separate set and clear command bits and which the hardware raises by itself whenever an OUT packet lands.

A protocol-engine stub drives per-endpoint event pulses into the block. Each pulse sets a sticky status bit that software clears by writing a one to it. A per-endpoint mask decides which status bits raise that endpoint's interrupt request. The stub receives the NAK and stall levels, the flush strobes and, for IN endpoints, the transmit-start strobe. OUT endpoint 2 has no storage of its own. Every access and every event aimed at it lands on OUT endpoint 0, and its outputs mirror OUT endpoint 0.

Address map: bit 9 selects OUT (1) or IN (0). Bits 6:5 select the endpoint. Bits 8:7 must be zero. Bits 4:2 select the register: 0 for control, 1 for status, 2 for mask.

Top module: `usb_ep_csr`

## Requirements
- R1: After reset, every control register reads 0x0000_0040 (only NAK set). Every status and mask register reads 0. All interrupt, stall, flush and start outputs are 0, and all NAK outputs are 1.
- R2: A control write stores stall (bit 0), endpoint kind (bits 5:4, 00 control, 01 isochronous, 10 bulk, 11 interrupt) and active (bit 10). These read back at the same positions and keep their value until the next control write. The stall output follows bit 0.
- R3: Writing 1 to flush (bit 1) gives a flush strobe for exactly the one cycle after the write. Writing 1 to poll (bit 3) of an IN endpoint does the same on the start strobe. Both bits read back as 0, including poll on an OUT endpoint.
- R4: Writing 1 to bit 7 sets NAK (read at bit 6). Writing 1 to bit 8 clears it. When both are written in one write, NAK becomes 1. Bits 7 and 8 read back as 0.
- R5: An OUT-received event (event index 0) on an OUT endpoint sets that endpoint's NAK in the next cycle, even when a clear-NAK write lands in the same cycle. IN endpoints' NAK is not affected.
- R6: Event index k (0..6) sets status bit k+4: OUT received, SETUP received, IN token, buffer unavailable, buffer error, bus error, transmit done. A status bit clears only when 1 is written to it. Writing 0 changes nothing. An event in the same cycle as a clear of the same bit leaves the bit at 1.
- R7: An endpoint's interrupt output is high exactly when some status bit is 1 and the matching mask bit is 0. The mask is written at the same bit positions as status.
- R8: Accesses to OUT endpoint 2 (offset 0x240) read and write OUT endpoint 0. Events on OUT endpoint 2 set OUT endpoint 0 status. The OUT endpoint 2 outputs equal those of OUT endpoint 0.
- R9: Addresses with bits 8:7 nonzero or register select 3..7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| in_evt | input | 28 | IN event pulses, 7 per endpoint, endpoint n at [7n+6:7n] |
| out_evt | input | 28 | OUT event pulses, same layout |
| in_nak | output | 4 | NAK level per IN endpoint |
| in_stall | output | 4 | Stall level per IN endpoint |
| in_flush | output | 4 | One-cycle flush strobe per IN endpoint |
| in_poll | output | 4 | One-cycle transmit-start strobe per IN endpoint |
| out_nak | output | 4 | NAK level per OUT endpoint |
| out_stall | output | 4 | Stall level per OUT endpoint |
| out_flush | output | 4 | One-cycle flush strobe per OUT endpoint |
| in_irq | output | 4 | Interrupt request per IN endpoint |
| out_irq | output | 4 | Interrupt request per OUT endpoint |

## Verification
The NAK logic is driven with set alone, clear alone, and set plus clear together. A clear-NAK write is also made to coincide with an OUT reception, which separates a priority error from a missing hardware set. Status bits are driven with multi-bit event patterns, partial write-one-to-clear, all-zero writes, and an event that collides with its own clear. These tell correct sticky clearing apart from plain overwrite or lost events. Alias and gap addresses are written with values that would visibly set stall if decoded wrongly, which exposes address-decode faults.

// File: rtl/usb_ep_csr_pkg.sv
package usb_ep_csr_pkg;
   localparam int CB_STALL  = 0;
   localparam int CB_FLUSH  = 1;
   localparam int CB_POLL   = 3;
   localparam int CB_KIND   = 4;
   localparam int CB_NAK    = 6;
   localparam int CB_SETNAK = 7;
   localparam int CB_CLRNAK = 8;
   localparam int CB_ACTIVE = 10;

   localparam int ST_LSB = 4;
   localparam int ST_W   = 7;
   localparam int EV_OUT_RX = 0;

   localparam int EP_LSB = 5;

   typedef enum logic [1:0] {
      KIND_CTRL = 2'b00,
      KIND_ISO  = 2'b01,
      KIND_BULK = 2'b10,
      KIND_INTR = 2'b11
   } ep_kind_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/usb_ep_csr_dec.sv
module usb_ep_csr_dec
   import usb_ep_csr_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int NUM_EP    = 4,
   parameter bit HAS_ALIAS = 1'b1,
   parameter int ALIAS_EP  = 2,
   parameter int ALIAS_TGT = 0,
   localparam int EP_W     = $clog2(NUM_EP)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              is_out,
   output logic [EP_W-1:0]   ep_idx,
   output reg_sel_e          sel
);
   localparam int DIR_BIT = ADDR_W - 1;
   localparam int GAP_LO  = EP_LSB + EP_W;

   logic [EP_W-1:0]     ep_raw;
   logic [EP_LSB-3:0]   offs;
   logic                gap_ok;
   logic [1:0]          unused_byte;

   assign ep_raw      = addr[EP_LSB +: EP_W];
   assign offs        = addr[EP_LSB-1:2];
   assign gap_ok      = (addr[DIR_BIT-1:GAP_LO] == '0);
   assign is_out      = addr[DIR_BIT];
   assign unused_byte = addr[1:0];

   always_comb begin
      case (offs)
         (EP_LSB-2)'(0): sel = SEL_CTRL;
         (EP_LSB-2)'(1): sel = SEL_STAT;
         (EP_LSB-2)'(2): sel = SEL_MASK;
         default:        sel = SEL_NONE;
      endcase
   end

   assign hit = gap_ok && (sel != SEL_NONE);

   generate
      if (HAS_ALIAS) begin : g_alias
         assign ep_idx = (is_out && ep_raw == EP_W'(ALIAS_EP)) ? EP_W'(ALIAS_TGT) : ep_raw;
      end else begin : g_plain
         assign ep_idx = ep_raw;
      end
   endgenerate
endmodule

// File: rtl/usb_ep_ctrl_reg.sv
module usb_ep_ctrl_reg
   import usb_ep_csr_pkg::*;
#(
   parameter bit IS_IN   = 1'b1,
   parameter bit NAK_RST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [31:0] wdata,
   input  logic        hw_nak_set,
   output logic        stall,
   output logic        nak,
   output logic        flush_pulse,
   output logic        poll_pulse,
   output logic [31:0] rd_val
);
   ep_kind_e kind_q;
   logic     active_q;
   logic     nak_next;
   logic     set_cmd, clr_cmd;
   logic     unused_bits;

   assign set_cmd     = wr & wdata[CB_SETNAK];
   assign clr_cmd     = wr & wdata[CB_CLRNAK];
   assign nak_next    = set_cmd | hw_nak_set | (nak & ~clr_cmd);
   assign unused_bits = ^{wdata[31:11], wdata[9], wdata[CB_NAK], wdata[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall       <= 1'b0;
         kind_q      <= KIND_CTRL;
         active_q    <= 1'b0;
         nak         <= NAK_RST;
         flush_pulse <= 1'b0;
      end else begin
         flush_pulse <= wr & wdata[CB_FLUSH];
         nak         <= nak_next;
         if (wr) begin
            stall    <= wdata[CB_STALL];
            kind_q   <= ep_kind_e'(wdata[CB_KIND +: 2]);
            active_q <= wdata[CB_ACTIVE];
         end
      end
   end

   generate
      if (IS_IN) begin : g_poll
         logic poll_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) poll_q <= 1'b0;
            else        poll_q <= wr & wdata[CB_POLL];
         end
         assign poll_pulse = poll_q;
      end else begin : g_nopoll
         assign poll_pulse = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_val                 = '0;
      rd_val[CB_STALL]       = stall;
      rd_val[CB_KIND +: 2]   = kind_q;
      rd_val[CB_NAK]         = nak;
      rd_val[CB_ACTIVE]      = active_q;
   end
endmodule

// File: rtl/usb_ep_stat_reg.sv
module usb_ep_stat_reg
   import usb_ep_csr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_wr,
   input  logic            mask_wr,
   input  logic [ST_W-1:0] wdata,
   input  logic [ST_W-1:0] evt,
   output logic [ST_W-1:0] status,
   output logic [ST_W-1:0] mask,
   output logic            irq
);
   logic [ST_W-1:0] clr_vec;

   assign clr_vec = st_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= (status & ~clr_vec) | evt;
         if (mask_wr) mask <= wdata;
      end
   end

   assign irq = |(status & ~mask);
endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
   import usb_ep_csr_pkg::*;
#(
   parameter int NUM_EP    = 4,
   parameter int ADDR_W    = 10,
   parameter bit HAS_ALIAS = 1'b1,
   parameter int ALIAS_EP  = 2,
   parameter int ALIAS_TGT = 0,
   parameter bit NAK_RST   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [NUM_EP*ST_W-1:0] in_evt,
   input  logic [NUM_EP*ST_W-1:0] out_evt,
   output logic [NUM_EP-1:0]      in_nak,
   output logic [NUM_EP-1:0]      in_stall,
   output logic [NUM_EP-1:0]      in_flush,
   output logic [NUM_EP-1:0]      in_poll,
   output logic [NUM_EP-1:0]      out_nak,
   output logic [NUM_EP-1:0]      out_stall,
   output logic [NUM_EP-1:0]      out_flush,
   output logic [NUM_EP-1:0]      in_irq,
   output logic [NUM_EP-1:0]      out_irq
);
   localparam int EP_W = $clog2(NUM_EP);

   generate
      if (NUM_EP < 2 || (1 << EP_W) != NUM_EP) begin : g_bad_num
         $error("NUM_EP must be a power of two of at least 2");
      end
      if (ADDR_W < EP_LSB + EP_W + 2) begin : g_bad_addr
         $error("ADDR_W leaves no gap bits above the endpoint field");
      end
      if (HAS_ALIAS && (ALIAS_EP >= NUM_EP || ALIAS_TGT >= NUM_EP || ALIAS_EP == ALIAS_TGT)) begin : g_bad_alias
         $error("alias endpoint numbers out of range");
      end
   endgenerate

   logic            hit, is_out;
   logic [EP_W-1:0] ep_idx;
   reg_sel_e        sel;

   usb_ep_csr_dec #(
      .ADDR_W(ADDR_W), .NUM_EP(NUM_EP), .HAS_ALIAS(HAS_ALIAS),
      .ALIAS_EP(ALIAS_EP), .ALIAS_TGT(ALIAS_TGT)
   ) u_dec (
      .addr(bus_addr), .hit(hit), .is_out(is_out), .ep_idx(ep_idx), .sel(sel)
   );

   logic [31:0]     in_ctrl_rd  [NUM_EP];
   logic [31:0]     out_ctrl_rd [NUM_EP];
   logic [ST_W-1:0] in_st       [NUM_EP];
   logic [ST_W-1:0] in_mk       [NUM_EP];
   logic [ST_W-1:0] out_st      [NUM_EP];
   logic [ST_W-1:0] out_mk      [NUM_EP];
   logic [NUM_EP-1:0] unused_out_poll;

   logic wr_hit;
   assign wr_hit = bus_wr & hit;

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_in
         logic sel_ep;
         assign sel_ep = wr_hit && !is_out && (ep_idx == EP_W'(i));

         usb_ep_ctrl_reg #(.IS_IN(1'b1), .NAK_RST(NAK_RST)) u_ctrl (
            .clk(clk), .rst_n(rst_n),
            .wr(sel_ep && sel == SEL_CTRL), .wdata(bus_wdata),
            .hw_nak_set(1'b0),
            .stall(in_stall[i]), .nak(in_nak[i]),
            .flush_pulse(in_flush[i]), .poll_pulse(in_poll[i]),
            .rd_val(in_ctrl_rd[i])
         );

         usb_ep_stat_reg u_stat (
            .clk(clk), .rst_n(rst_n),
            .st_wr(sel_ep && sel == SEL_STAT),
            .mask_wr(sel_ep && sel == SEL_MASK),
            .wdata(bus_wdata[ST_LSB +: ST_W]),
            .evt(in_evt[i*ST_W +: ST_W]),
            .status(in_st[i]), .mask(in_mk[i]), .irq(in_irq[i])
         );
      end

      for (genvar i = 0; i < NUM_EP; i++) begin : g_out
         if (HAS_ALIAS && i == ALIAS_EP) begin : g_mirror
            assign out_nak[i]         = out_nak[ALIAS_TGT];
            assign out_stall[i]       = out_stall[ALIAS_TGT];
            assign out_flush[i]       = out_flush[ALIAS_TGT];
            assign out_irq[i]         = out_irq[ALIAS_TGT];
            assign out_ctrl_rd[i]     = out_ctrl_rd[ALIAS_TGT];
            assign out_st[i]          = out_st[ALIAS_TGT];
            assign out_mk[i]          = out_mk[ALIAS_TGT];
            assign unused_out_poll[i] = 1'b0;
         end else begin : g_store
            logic            sel_ep;
            logic [ST_W-1:0] evt_eff;
            assign sel_ep = wr_hit && is_out && (ep_idx == EP_W'(i));

            if (HAS_ALIAS && i == ALIAS_TGT) begin : g_merge
               assign evt_eff = out_evt[i*ST_W +: ST_W] | out_evt[ALIAS_EP*ST_W +: ST_W];
            end else begin : g_own
               assign evt_eff = out_evt[i*ST_W +: ST_W];
            end

            usb_ep_ctrl_reg #(.IS_IN(1'b0), .NAK_RST(NAK_RST)) u_ctrl (
               .clk(clk), .rst_n(rst_n),
               .wr(sel_ep && sel == SEL_CTRL), .wdata(bus_wdata),
               .hw_nak_set(evt_eff[EV_OUT_RX]),
               .stall(out_stall[i]), .nak(out_nak[i]),
               .flush_pulse(out_flush[i]), .poll_pulse(unused_out_poll[i]),
               .rd_val(out_ctrl_rd[i])
            );

            usb_ep_stat_reg u_stat (
               .clk(clk), .rst_n(rst_n),
               .st_wr(sel_ep && sel == SEL_STAT),
               .mask_wr(sel_ep && sel == SEL_MASK),
               .wdata(bus_wdata[ST_LSB +: ST_W]),
               .evt(evt_eff),
               .status(out_st[i]), .mask(out_mk[i]), .irq(out_irq[i])
            );
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sel)
            SEL_CTRL: bus_rdata = is_out ? out_ctrl_rd[ep_idx] : in_ctrl_rd[ep_idx];
            SEL_STAT: bus_rdata[ST_LSB +: ST_W] = is_out ? out_st[ep_idx] : in_st[ep_idx];
            SEL_MASK: bus_rdata[ST_LSB +: ST_W] = is_out ? out_mk[ep_idx] : in_mk[ep_idx];
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/usb_ep_csr_chk.sv
module usb_ep_csr_chk
   import usb_ep_csr_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int ADDR_W = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [31:0]            bus_wdata,
   input logic [NUM_EP*ST_W-1:0] in_evt,
   input logic [NUM_EP*ST_W-1:0] out_evt,
   input logic [NUM_EP-1:0]      in_nak,
   input logic [NUM_EP-1:0]      in_stall,
   input logic [NUM_EP-1:0]      in_flush,
   input logic [NUM_EP-1:0]      in_poll,
   input logic [NUM_EP-1:0]      out_nak,
   input logic [NUM_EP-1:0]      out_stall,
   input logic [NUM_EP-1:0]      out_flush,
   input logic [NUM_EP-1:0]      in_irq,
   input logic [NUM_EP-1:0]      out_irq
);
   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         // R3: strobes only ever follow a bus write
         assert_poll_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_poll[i] |-> $past(bus_wr));
         assert_flush_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_flush[i] || out_flush[i]) |-> $past(bus_wr));
         // R2: stall level moves only after a write
         assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(bus_wr) |-> $stable(in_stall[i]));
         // R7: an interrupt rises only from an event or a mask/status write
         assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_irq[i]) |-> ($past(|in_evt[i*ST_W +: ST_W]) || $past(bus_wr)));
      end

      if (NUM_EP > 2) begin : g_alias
         // R8: alias endpoint outputs mirror the target
         assert_alias_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_nak[2] == out_nak[0]) && (out_stall[2] == out_stall[0]) && (out_irq[2] == out_irq[0]));
      end
   endgenerate

   // R5: OUT reception forces NAK next cycle
   assert_rx_sets_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_evt[EV_OUT_RX] |=> out_nak[0]);

   // R4: set-NAK command on IN endpoint 0 control
   assert_setnak_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && bus_wdata[CB_SETNAK]) |=> in_nak[0]);
endmodule

bind usb_ep_csr usb_ep_csr_chk #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .in_evt(in_evt), .out_evt(out_evt), .in_nak(in_nak), .in_stall(in_stall),
   .in_flush(in_flush), .in_poll(in_poll), .out_nak(out_nak), .out_stall(out_stall),
   .out_flush(out_flush), .in_irq(in_irq), .out_irq(out_irq)
);

// File: tb/usb_ep_csr_tb.sv
module usb_ep_csr_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NEP = 4;
   localparam int SW  = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [9:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NEP*SW-1:0] in_evt = '0;
   logic [NEP*SW-1:0] out_evt = '0;
   logic [NEP-1:0]   in_nak, in_stall, in_flush, in_poll;
   logic [NEP-1:0]   out_nak, out_stall, out_flush, in_irq, out_irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_ep_csr dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_evt(in_evt), .out_evt(out_evt),
      .in_nak(in_nak), .in_stall(in_stall), .in_flush(in_flush), .in_poll(in_poll),
      .out_nak(out_nak), .out_stall(out_stall), .out_flush(out_flush),
      .in_irq(in_irq), .out_irq(out_irq)
   );

   function automatic logic [9:0] a_in(int ep, int r);
      return 10'(ep * 32 + r * 4);
   endfunction
   function automatic logic [9:0] a_out(int ep, int r);
      return 10'(512 + ep * 32 + r * 4);
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [9:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(bit is_out, int ep, logic [SW-1:0] bits);
      @(negedge clk);
      if (is_out) out_evt[ep*SW +: SW] = bits; else in_evt[ep*SW +: SW] = bits;
      @(negedge clk);
      out_evt = '0; in_evt = '0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(a_in(0, 0), v);  chk("R1 in0 ctrl", v, 32'h40);
      rd(a_out(1, 0), v); chk("R1 out1 ctrl", v, 32'h40);
      rd(a_in(3, 1), v);  chk("R1 in3 status", v, 0);
      rd(a_out(3, 2), v); chk("R1 out3 mask", v, 0);
      chk("R1 irq", {24'b0, in_irq, out_irq}, 0);
      chk("R1 nak", {24'b0, in_nak, out_nak}, 32'hFF);
      chk("R1 strobes", {20'b0, in_stall, in_flush, in_poll}, 0);
   endtask

   task automatic t_fields;
      logic [31:0] v;
      wr(a_in(1, 0), 32'h421);
      rd(a_in(1, 0), v); chk("R2 in1 readback", v, 32'h461);
      chk("R2 in1 stall", 32'(in_stall[1]), 1);
      repeat (3) @(negedge clk);
      rd(a_in(1, 0), v); chk("R2 in1 held", v, 32'h461);
      wr(a_out(3, 0), 32'h030);
      rd(a_out(3, 0), v); chk("R2 out3 kind", v, 32'h070);
      chk("R2 out3 stall", 32'(out_stall[3]), 0);
   endtask

   task automatic t_strobes;
      logic [31:0] v;
      wr(a_in(2, 0), 32'h0A);
      chk("R3 in2 flush", 32'(in_flush[2]), 1);
      chk("R3 in2 poll", 32'(in_poll[2]), 1);
      @(negedge clk);
      chk("R3 in2 strobes drop", {30'b0, in_flush[2], in_poll[2]}, 0);
      rd(a_in(2, 0), v); chk("R3 in2 readback", v, 32'h40);
      wr(a_out(1, 0), 32'h0A);
      chk("R3 out1 flush", 32'(out_flush[1]), 1);
      rd(a_out(1, 0), v); chk("R3 out1 readback", v, 32'h40);
   endtask

   task automatic t_nak;
      logic [31:0] v;
      wr(a_in(0, 0), 32'h100);
      chk("R4 clear", 32'(in_nak[0]), 0);
      rd(a_in(0, 0), v); chk("R4 clear readback", v, 32'h0);
      wr(a_in(0, 0), 32'h080);
      chk("R4 set", 32'(in_nak[0]), 1);
      rd(a_in(0, 0), v); chk("R4 set readback", v, 32'h40);
      wr(a_in(0, 0), 32'h100);
      wr(a_in(0, 0), 32'h180);
      chk("R4 both set wins", 32'(in_nak[0]), 1);
   endtask

   task automatic t_rx_nak;
      logic [31:0] v;
      wr(a_out(1, 0), 32'h100);
      wr(a_in(1, 0), 32'h100);
      chk("R5 out1 cleared", 32'(out_nak[1]), 0);
      pulse(1'b1, 1, 7'b0000001);
      chk("R5 rx sets nak", 32'(out_nak[1]), 1);
      chk("R5 in1 untouched", 32'(in_nak[1]), 0);
      rd(a_out(1, 1), v); chk("R6 rx status bit4", v, 32'h10);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a_out(1, 0); bus_wdata = 32'h100;
      out_evt[1*SW +: SW] = 7'b0000001;
      @(negedge clk);
      bus_wr = 1'b0; out_evt = '0;
      chk("R5 rx beats clear", 32'(out_nak[1]), 1);
      wr(a_out(1, 1), 32'h10);
   endtask

   task automatic t_status;
      logic [31:0] v;
      pulse(1'b0, 3, 7'b1000001);
      rd(a_in(3, 1), v); chk("R6 set bits", v, 32'h410);
      wr(a_in(3, 1), 32'h010);
      rd(a_in(3, 1), v); chk("R6 partial clear", v, 32'h400);
      wr(a_in(3, 1), 32'h0);
      rd(a_in(3, 1), v); chk("R6 zero write", v, 32'h400);
      wr(a_in(3, 1), 32'h400);
      rd(a_in(3, 1), v); chk("R6 clear", v, 32'h0);
      pulse(1'b0, 3, 7'b1000000);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a_in(3, 1); bus_wdata = 32'h400;
      in_evt[3*SW +: SW] = 7'b1000000;
      @(negedge clk);
      bus_wr = 1'b0; in_evt = '0;
      rd(a_in(3, 1), v); chk("R6 event beats clear", v, 32'h400);
      wr(a_in(3, 1), 32'h400);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      wr(a_in(3, 2), 32'h400);
      rd(a_in(3, 2), v); chk("R7 mask readback", v, 32'h400);
      pulse(1'b0, 3, 7'b1000000);
      chk("R7 masked", 32'(in_irq[3]), 0);
      wr(a_in(3, 2), 32'h0);
      chk("R7 unmasked", 32'(in_irq[3]), 1);
      wr(a_in(3, 1), 32'h400);
      chk("R7 cleared", 32'(in_irq[3]), 0);
   endtask

   task automatic t_alias;
      logic [31:0] v;
      wr(a_out(2, 0), 32'h001);
      chk("R8 out0 stall", 32'(out_stall[0]), 1);
      chk("R8 out2 mirror", 32'(out_stall[2]), 1);
      rd(a_out(0, 0), v); chk("R8 out0 ctrl", v, 32'h41);
      pulse(1'b1, 2, 7'b0000010);
      rd(a_out(0, 1), v); chk("R8 out0 status", v, 32'h20);
      chk("R8 out0 irq", 32'(out_irq[0]), 1);
      wr(a_out(2, 1), 32'h20);
      rd(a_out(0, 1), v); chk("R8 alias clear", v, 32'h0);
      wr(a_out(0, 0), 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      rd(10'h00C, v); chk("R9 sel3 read", v, 0);
      rd(10'h080, v); chk("R9 gap read", v, 0);
      wr(10'h080, 32'h001);
      chk("R9 gap write", 32'(in_stall[0]), 0);
      wr(10'h00C, 32'hFFFFFFFF);
      rd(a_in(0, 0), v); chk("R9 in0 untouched", v, 32'h40);
      rd(a_in(0, 2), v); chk("R9 in0 mask untouched", v, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_strobes();
      t_nak();
      t_rx_nak();
      t_status();
      t_irq();
      t_alias();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule